// File: doc/BRIEF.md
# Dual-Style Overlapping 1-0-1 Serial Recognizer

This block watches a serial single-bit stream, one bit per clock, and flags every point where the bits received since reset end in 1, 0, 1. Matches may overlap, so the final 1 of one match can be the first 1 of the next. Two flags are built from the same input by two independent state machines, and they describe the same event at different times.

The first flag comes from a four-state, state-based machine. Its two state bits use a fixed binary code, and its next-state logic is written as sum-of-products equations. The flag is high while that machine sits in its accepting code, and it stays stable for a full clock period. The second flag comes from a reduced, transition-based machine with three states. In that machine the "last bit was 1" state and the accepting state are merged into one. Its flag is a combinational function of the present state and the present input, so it is valid during the cycle in which the closing 1 is presented. The state-based flag follows exactly one clock later.

Top module: `pat101_dual`

## Requirements
- R1: A clock edge with `rst` high puts both machines in code 00. From the cycle after that edge, `moore_hit` and `mealy_hit` are both 0, whatever the value on `din`.
- R2: The state-based machine uses a fixed code on its state bits (MSB, LSB). The codes are 00 for nothing matched, 01 for a trailing 1, 10 for a trailing 1-0, and 11 for accept. It enters 11 on the clock edge that samples the closing 1 of 1-0-1. `moore_hit` is high for the whole period that follows.
- R3: Matches overlap. The stream 1,0,1,0,1 gives hits on the 3rd and 5th bits. The stream 1,1,1,1,0,1 gives a hit only on the 6th bit. The stream 1,1,0,1,0,1,1,0,0 gives hits on the 4th and 6th bits.
- R4: `mealy_hit` is 1 during the same cycle in which `din` carries the closing 1, before the clock edge that samples it.
- R5: After reset, in every cycle, `moore_hit` equals the value `mealy_hit` had one cycle earlier.
- R6: The transition-based machine never enters its unused code 11 after reset. `mealy_hit` is 1 only when `din` is 1 and the two previous bits received since reset were 1 and then 0.
- R7: `moore_hit` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset for both machines |
| din | input | 1 | Serial data bit, sampled each rising edge |
| moore_hit | output | 1 | Registered accept flag from the four-state machine |
| mealy_hit | output | 1 | Combinational match flag from the three-state machine |

## Verification
A wrong state bit in either machine shows up at the ports within one or two input bits. A missed or extra `mealy_hit` appears in the very cycle the closing 1 is presented. A corrupted state-based code breaks the fixed one-cycle lag between the two flags on the next match. Both flags are compared every cycle against a three-bit history model that also counts the bits received since reset. This catches errors in overlap handling, in the early bits just after reset, and in recovery from reset taken in the middle of a match.

// File: rtl/pat101_dual.sv
module pat101_dual (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic moore_hit,
  output logic mealy_hit
);

  // state-based machine: {A,B} = 00 idle, 01 saw 1, 10 saw 10, 11 accept
  logic [1:0] moore_st;
  logic       mo_a_nx, mo_b_nx;

  assign mo_a_nx = (~din & moore_st[0]) | (din & moore_st[1] & ~moore_st[0]);
  assign mo_b_nx = din;

  always_ff @(posedge clk) begin
    if (rst) moore_st <= 2'b00;
    else     moore_st <= {mo_a_nx, mo_b_nx};
  end

  assign moore_hit = moore_st[1] & moore_st[0];

  // transition-based machine: 00 idle, 01 saw 1 (merged with accept), 10 saw 10
  logic [1:0] mealy_st;
  logic       me_a_nx, me_b_nx;

  assign me_a_nx = ~din & mealy_st[0];
  assign me_b_nx = din;

  always_ff @(posedge clk) begin
    if (rst) mealy_st <= 2'b00;
    else     mealy_st <= {me_a_nx, me_b_nx};
  end

  assign mealy_hit = din & mealy_st[1];

endmodule

module pat101_dual_chk (
  input logic       clk,
  input logic       rst,
  input logic       din,
  input logic       moore_hit,
  input logic       mealy_hit,
  input logic [1:0] moore_st,
  input logic [1:0] mealy_st
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (moore_st == 2'b00 && mealy_st == 2'b00 && !moore_hit));

  assert_accept_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(mealy_st) == 2'b10 && $past(din)) |-> moore_st == 2'b11);

  assert_lag_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    armed |-> moore_hit == $past(mealy_hit));

  assert_no_illegal_code_R6: assert property (@(posedge clk) disable iff (rst)
    armed |-> mealy_st != 2'b11);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    moore_hit |=> !moore_hit);

endmodule

bind pat101_dual pat101_dual_chk u_chk (
  .clk(clk), .rst(rst), .din(din), .moore_hit(moore_hit),
  .mealy_hit(mealy_hit), .moore_st(moore_st), .mealy_st(mealy_st)
);

// File: tb/sim_pat101_dual.sv
`timescale 1ns/1ps
module sim_pat101_dual;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic moore_hit, mealy_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  pat101_dual u0 (.clk(clk), .rst(rst), .din(din), .moore_hit(moore_hit), .mealy_hit(mealy_hit));

  always #2.5 clk = ~clk;

  // stimulus table: bit i is the i-th bit sent after reset
  localparam int NV = 4;
  localparam logic [11:0] VBITS [NV] = '{12'h06B, 12'h015, 12'h02F, 12'h069};
  localparam logic [11:0] VHITS [NV] = '{12'h028, 12'h014, 12'h020, 12'h020};
  localparam int          VLEN  [NV] = '{9, 5, 6, 7};

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic step(input logic d, input logic e_me, input logic e_mo,
                      input string rme, input string rmo);
    @(negedge clk);
    din = d;
    #1;
    check(mealy_hit, e_me, rme);
    check(moore_hit, e_mo, rmo);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    din = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(mealy_hit, 1'b0, "R1 mealy in reset");
    check(moore_hit, 1'b0, "R1 moore in reset");
    @(negedge clk);
    rst = 1'b0;
    din = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL R5 watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic prev;
    logic e;
    logic [1:0] hist;
    int cnt;

    // table walk: R2, R3, R4, R7
    for (int v = 0; v < NV; v++) begin
      do_reset();
      prev = 1'b0;
      for (int i = 0; i < VLEN[v]; i++) begin
        e = VHITS[v][i];
        step(VBITS[v][i], e, prev, "R3 R4 mealy", "R2 R7 moore");
        prev = e;
      end
      step(1'b0, 1'b0, prev, "R4 tail", "R2 tail");
      step(1'b0, 1'b0, 1'b0, "R4 tail", "R7 tail");
    end

    // reset taken in the middle of a match (R1)
    do_reset();
    step(1'b1, 1'b0, 1'b0, "R6", "R5");
    step(1'b0, 1'b0, 1'b0, "R6", "R5");
    @(negedge clk);
    rst = 1'b1;
    din = 1'b1;
    @(negedge clk);
    #1;
    check(mealy_hit, 1'b0, "R1 reset mid-match mealy");
    check(moore_hit, 1'b0, "R1 reset mid-match moore");
    @(negedge clk);
    rst = 1'b0;
    din = 1'b0;
    #1;
    check(moore_hit, 1'b0, "R1 after release moore");
    step(1'b1, 1'b0, 1'b0, "R1 R6 no stale match", "R1");

    // bits right after reset: 0,1 must not match (R6)
    do_reset();
    step(1'b0, 1'b0, 1'b0, "R6", "R5");
    step(1'b1, 1'b0, 1'b0, "R6", "R5");

    // long random stream against history model (R5, R6)
    do_reset();
    hist = 2'b00;
    cnt  = 0;
    prev = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      logic d;
      d = 1'($urandom_range(0, 1));
      e = d && (cnt >= 2) && hist[1] && !hist[0];
      step(d, e, prev, "R6 random mealy", "R5 random moore");
      hist = {hist[0], d};
      cnt++;
      prev = e;
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule